// File: doc/BRIEF.md
# Protected Octal Latched Output Controller

This block is the synchronous control core of an eight-channel low-side output driver. An 8-bit data bus is captured into per-channel latches under an active-high load strobe. An active-high clear empties the latches. A combined output-enable/reset input, active high, turns every channel off and also clears fault state. The analog stage supplies, as digital inputs, one over-current sense bit per channel, an over-temperature indication and an undervoltage indication. From these the block drives eight channel-on controls and an active-low fault flag.

Each channel has its own over-current protection. A sense bit must stay high for a set number of consecutive clock cycles before the channel trips, so short pulses are ignored. A tripped channel stays off until the output-enable/reset input is raised or the block is reset. Over-temperature forces all channels off and pulls the flag low only while it lasts. Undervoltage acts exactly like a high output-enable/reset. All inputs are sampled on one clock, and every output is registered, so an output reflects the inputs sampled at the previous rising edge.

Top module: `octal_drv_ctrl`

## Requirements
- R1: While the load strobe is high at a clock edge, each data bit is stored in its channel latch; while the strobe is low the latches keep their value.
- R2: A high clear at a clock edge sets all eight latches to off (0), even when the strobe is high in the same cycle.
- R3: A high output-enable/reset at a clock edge drives all eight channel-on outputs to 0 after that edge, whatever the other inputs are.
- R4: A qualified over-current on channel n turns off only bit n of the channel-on bus and drives the fault flag low; the other channels keep following their latches.
- R5: A channel trips only when its sense bit has been high on QUAL_CYCLES consecutive clock edges, with output-enable/reset and undervoltage low. A shorter pulse has no effect, and a drop of the sense bit restarts the count from zero.
- R6: A tripped channel stays off and the flag stays low after its sense bit falls. Both recover only when output-enable/reset is high at an edge or the block is reset. The qualification count is held at zero while output-enable/reset is high.
- R7: While over-temperature is high, all channel-on outputs are 0 and the flag is low. Once it falls, the outputs return to their latched values and the flag goes high in the next cycle, with no reset pulse.
- R8: A high undervoltage indication acts exactly as a high output-enable/reset: all outputs off and all tripped channels cleared.
- R9: The fault flag is a registered output. It is low exactly when some channel is tripped or over-temperature was high at the last edge.
- R10: With the synchronous active-low reset applied, all channel-on outputs are 0 and the flag is 1. The latches, trip state and counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | 8 | Parallel channel data, bit n for channel n, 1 = on |
| strobe | input | 1 | Latch load, active high |
| clear | input | 1 | Latch clear, active high |
| outEnRst | input | 1 | Output disable and fault reset, active high |
| ocSense | input | 8 | Per-channel over-current sense, active high |
| overTemp | input | 1 | Over-temperature indication, active high |
| underVolt | input | 1 | Undervoltage indication, active high |
| chOn | output | 8 | Registered channel-on controls, 1 = on |
| flagN | output | 1 | Registered fault flag, active low |

## Verification
The in-RTL properties hold on every cycle. Clear empties the latches in the next cycle, a disable blanks the outputs and raises the flag unless temperature is high, and over-temperature blanks the outputs and lowers the flag. They also check that a channel trip never rises without sense having been high and that a trip is sticky while no disable is present. The exact qualification length, the restart on a short dropout, isolation of one tripped channel from the others, and recovery only through a disable pulse depend on multi-cycle histories. These are shown only by the bench's directed scenarios and by its cycle-accurate reference model under random stimulus.

// File: rtl/octal_drv_pkg.sv
package octal_drv_pkg;
  // Control strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic latchLoad;   // copy data bus into latches
    logic latchClear;  // empty latches (wins over load)
    logic forceOff;    // disable outputs and reset trips
    logic tempOff;     // non-latched thermal blanking
  } drvStrobes_t;
endpackage

// File: rtl/octal_drv_seq.sv
module octal_drv_seq
  import octal_drv_pkg::*;
(
  input  logic        strobe,
  input  logic        clear,
  input  logic        outEnRst,
  input  logic        underVolt,
  input  logic        overTemp,
  output drvStrobes_t ctl
);
  always_comb begin
    ctl.latchClear = clear;
    ctl.latchLoad  = strobe && !clear;
    ctl.forceOff   = outEnRst || underVolt;
    ctl.tempOff    = overTemp;
  end
endmodule

// File: rtl/octal_drv_path.sv
module octal_drv_path
  import octal_drv_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int QUAL_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  drvStrobes_t       ctl,
  input  logic [NUM_CH-1:0] dataIn,
  input  logic [NUM_CH-1:0] ocSense,
  output logic [NUM_CH-1:0] chOn,
  output logic              flagN
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(QUAL_CYCLES);
  localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(QUAL_CYCLES - 1);

  logic [NUM_CH-1:0] latchQ, latchNext;
  logic [NUM_CH-1:0] faultQ, faultNext;
  logic [NUM_CH-1:0] onNext;
  logic              flagNext;

  always_comb begin
    if (ctl.latchClear)     latchNext = '0;
    else if (ctl.latchLoad) latchNext = dataIn;
    else                    latchNext = latchQ;
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [CNT_W-1:0] cntQ;
      logic             tripNow;

      assign tripNow = ocSense[ch] && !ctl.forceOff && (cntQ == CNT_TRIP);

      always_ff @(posedge clk) begin
        if (!rstN)                            cntQ <= '0;
        else if (ctl.forceOff || !ocSense[ch]) cntQ <= '0;
        else if (cntQ != CNT_TOP)             cntQ <= cntQ + 1'b1;
      end

      assign faultNext[ch] = ctl.forceOff ? 1'b0 : (faultQ[ch] || tripNow);

      // R5
      trip_needs_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(faultQ[ch]) |-> $past(ocSense[ch]));
      // R6
      trip_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
        (faultQ[ch] && !ctl.forceOff) |=> faultQ[ch]);
    end
  endgenerate

  always_comb begin
    onNext   = latchNext & ~faultNext & {NUM_CH{!(ctl.forceOff || ctl.tempOff)}};
    flagNext = !((|faultNext) || ctl.tempOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      faultQ <= '0;
      chOn   <= '0;
      flagN  <= 1'b1;
    end else begin
      latchQ <= latchNext;
      faultQ <= faultNext;
      chOn   <= onNext;
      flagN  <= flagNext;
    end
  end

  // R2
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchClear |=> (latchQ == '0));
  // R3
  disable_blanks_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceOff |=> (chOn == '0));
  // R6
  disable_resets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.forceOff && !ctl.tempOff) |=> flagN);
  // R7
  thermal_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tempOff |=> (!flagN && chOn == '0));
endmodule

// File: rtl/octal_drv_ctrl.sv
module octal_drv_ctrl
  import octal_drv_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int QUAL_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dataIn,
  input  logic              strobe,
  input  logic              clear,
  input  logic              outEnRst,
  input  logic [NUM_CH-1:0] ocSense,
  input  logic              overTemp,
  input  logic              underVolt,
  output logic [NUM_CH-1:0] chOn,
  output logic              flagN
);
  drvStrobes_t ctl;

  octal_drv_seq u_seq (
    .strobe    (strobe),
    .clear     (clear),
    .outEnRst  (outEnRst),
    .underVolt (underVolt),
    .overTemp  (overTemp),
    .ctl       (ctl)
  );

  octal_drv_path #(.NUM_CH(NUM_CH), .QUAL_CYCLES(QUAL_CYCLES)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .ocSense (ocSense),
    .chOn    (chOn),
    .flagN   (flagN)
  );
endmodule

// File: tb/octal_drv_ctrl_bench.sv
`timescale 1ns/1ps
module octal_drv_ctrl_bench;
  localparam int QUAL = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] dataIn, ocSense;
  logic       strobe, clear, outEnRst, overTemp, underVolt;
  logic [7:0] chOn;
  logic       flagN;

  int checks = 0;
  int errors = 0;
  string phase = "R10";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  octal_drv_ctrl #(.NUM_CH(8), .QUAL_CYCLES(QUAL)) u_octal_drv_ctrl (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe), .clear(clear),
    .outEnRst(outEnRst), .ocSense(ocSense), .overTemp(overTemp),
    .underVolt(underVolt), .chOn(chOn), .flagN(flagN)
  );

  // Behavioural reference model
  bit [7:0] mLatch, mTrip, mOut;
  bit       mFlagN;
  int       mRun[8];

  always @(posedge clk) begin
    if (!rstN) begin
      mLatch = 0; mTrip = 0; mOut = 0; mFlagN = 1;
      for (int i = 0; i < 8; i++) mRun[i] = 0;
    end else begin
      bit dis;
      dis = outEnRst || underVolt;
      if (clear) mLatch = 0;
      else if (strobe) mLatch = dataIn;
      for (int i = 0; i < 8; i++) begin
        if (dis) begin
          mTrip[i] = 0; mRun[i] = 0;
        end else if (!ocSense[i]) begin
          mRun[i] = 0;
        end else begin
          mRun[i] = mRun[i] + 1;
          if (mRun[i] >= QUAL) mTrip[i] = 1;
        end
      end
      mOut = (dis || overTemp) ? 8'h00 : (mLatch & ~mTrip);
      mFlagN = !((mTrip != 0) || overTemp);
    end
  end

  task automatic cmp(string req, logic [7:0] expOn, logic expFlag);
    checks++;
    if (chOn !== expOn || flagN !== expFlag) begin
      errors++;
      $display("FAIL %s chOn=%h flagN=%b expected chOn=%h flagN=%b", req, chOn, flagN, expOn, expFlag);
    end
  endtask

  // one clock, then compare against the model away from the edge
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rstN) cmp({phase, " model"}, mOut, mFlagN);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired chOn=%h expected run end", chOn);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; dataIn = 0; ocSense = 0; strobe = 0; clear = 0;
    outEnRst = 0; overTemp = 0; underVolt = 0;
    repeat (3) @(negedge clk);
    cmp("R10 reset", 8'h00, 1'b1);
    rstN = 1;

    phase = "R1";
    dataIn = 8'hA5; strobe = 1; step();
    strobe = 0; dataIn = 8'hFF; step(2);
    cmp("R1 hold", 8'hA5, 1'b1);

    phase = "R2";
    clear = 1; strobe = 1; step();
    cmp("R2 clear over strobe", 8'h00, 1'b1);
    clear = 0; dataIn = 8'h3C; step(); strobe = 0; step();
    cmp("R1 reload", 8'h3C, 1'b1);

    phase = "R3";
    outEnRst = 1; dataIn = 8'hFF; step();
    cmp("R3 disable", 8'h00, 1'b1);
    outEnRst = 0; step();
    cmp("R3 release", 8'h3C, 1'b1);

    phase = "R5";
    ocSense[2] = 1; step(QUAL - 1); ocSense[2] = 0; step();
    cmp("R5 short pulse ignored", 8'h3C, 1'b1);
    ocSense[2] = 1; step(QUAL - 2); ocSense[2] = 0; step();
    ocSense[2] = 1; step(QUAL - 1);
    cmp("R5 count restarts", 8'h3C, 1'b1);
    phase = "R4";
    step();
    cmp("R4 trip one channel", 8'h38, 1'b0);
    ocSense[2] = 0; step(3);
    cmp("R6 trip sticky", 8'h38, 1'b0);

    phase = "R6";
    ocSense[4] = 1; outEnRst = 1; step(QUAL + 2);
    cmp("R6 disable clears trip", 8'h00, 1'b1);
    outEnRst = 0; ocSense[4] = 0; step();
    cmp("R6 restored", 8'h3C, 1'b1);

    phase = "R8";
    ocSense[3] = 1; step(QUAL); ocSense[3] = 0; step();
    cmp("R8 trip before undervolt", 8'h34, 1'b0);
    underVolt = 1; step();
    cmp("R8 undervolt blanks", 8'h00, 1'b1);
    underVolt = 0; step();
    cmp("R8 undervolt cleared trip", 8'h3C, 1'b1);

    phase = "R7";
    overTemp = 1; step();
    cmp("R7 thermal blank", 8'h00, 1'b0);
    overTemp = 0; step();
    cmp("R7 thermal auto recover", 8'h3C, 1'b1);

    phase = "R9";
    for (int c = 0; c < 3000; c++) begin
      dataIn    = 8'($urandom);
      strobe    = ($urandom % 4) == 0;
      clear     = ($urandom % 20) == 0;
      outEnRst  = ($urandom % 40) == 0;
      underVolt = ($urandom % 60) == 0;
      overTemp  = ($urandom % 50) == 0;
      for (int i = 0; i < 8; i++)
        if (($urandom % 6) == 0) ocSense[i] = !ocSense[i];
      step();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule